// File: doc/BRIEF.md
# Asymmetric Four-Switch Inverter PWM Sequencer

This block drives the gates of the two switched legs (A and B) of a three-phase inverter built from four switches. The third phase sits on the midpoint of a split DC-link capacitor. For each carrier period the block takes one of six commutation modes and a duty command. It then steps each leg through the states driven-high, driven-low and floating. In two of the modes the whole bus is applied across the winding. In those modes the period is split into an active stage, a freewheel stage and a final stage with every switch off, so the capacitor cannot discharge through a low-side switch. In the other four modes only half of the bus is applied, so the on-time is twice the commanded duty.

The carrier is an up-counter that advances on a tick strobe. Its period length, the length of the freewheel stage, the duty and the mode are all sampled together at the start of each period. A change on these inputs therefore never cuts a period short. An enable input starts and stops the sequencer. While it is low, every gate is off.

Top module: `fsw_pwm_seq`

## Requirements
- R1: After reset all four gates are low, and they stay low until `en` is asserted.
- R2: Each leg is encoded on its gate pair (hi,lo) as driven-high=(1,0), driven-low=(0,1) and floating=(0,0). Mode codes 1 to 6 give these active (A,B) pairs: 1=(float,low), 2=(high,low), 3=(high,float), 4=(float,high), 5=(low,high), 6=(low,float).
- R3: In modes 2 and 5, with carrier count c, duty d and freewheel length f: for c<d the full active pair is applied. For d<=c<d+f leg A floats while leg B keeps its active state. For c>=d+f both legs float.
- R4: In modes 1, 3, 4 and 6 the driven leg holds its active state while c<2*d and floats otherwise. When 2*d reaches or exceeds the period, the leg is on for the whole period.
- R5: The carrier count starts at 0 and advances by one on each clock with `tick` high. It wraps to 0 after reaching period-1. A period setting of 0 or 1 gives a one-tick period.
- R6: `mode`, `duty`, `fw_len` and `period` are sampled only on the first cycle after `en` rises and on the tick that wraps the count. Changes at any other time have no effect until the next period starts.
- R7: Mode codes 0 and 7 keep all gates off.
- R8: The high and low gate of one leg are never on in the same cycle.
- R9: On the clock edge after `en` falls, every gate turns off. The count restarts from 0 when `en` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| tick | input | 1 | Carrier advance strobe |
| mode | input | 3 | Commutation mode code (1 to 6) |
| duty | input | CW | Duty command in ticks |
| period | input | CW | Carrier period in ticks |
| fw_len | input | CW | Freewheel stage length in ticks (modes 2 and 5) |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |

## Verification
The bench runs random segments that mix all eight mode codes with random duty, period, freewheel length and tick gaps. The segment boundaries fall mid-period on purpose, so a design that applies a new mode or duty early produces different gate patterns from one that waits for the wrap. Directed cases follow. A zero freewheel length tells whether the three-stage sequence in modes 2 and 5 collapses correctly. A duty of half the period or more tells whether the doubled duty saturates. A zero duty must give an all-off period. An enable drop followed by re-enable tells whether the count restarts from zero.

// File: rtl/fsw_pwm_seq.sv
module fsw_pwm_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [2:0]    mode,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] fw_len,
  output logic          a_hi,
  output logic          a_lo,
  output logic          b_hi,
  output logic          b_lo
);
  localparam logic [1:0] FLT = 2'd0, HI = 2'd1, LO = 2'd2;

  logic          run;
  logic [CW-1:0] cnt, duty_q, fw_q, per_q;
  logic [2:0]    mode_q;

  logic [CW:0] c_w, d_w, d2_w, dfw_w;
  assign c_w   = {1'b0, cnt};
  assign d_w   = {1'b0, duty_q};
  assign d2_w  = {duty_q, 1'b0};
  assign dfw_w = d_w + {1'b0, fw_q};

  logic last, start;
  assign last  = (c_w + 1'b1) >= {1'b0, per_q};
  assign start = en && (!run || (tick && last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; mode_q <= '0;
      duty_q <= '0; fw_q <= '0; per_q <= '0;
    end else begin
      if (!en) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        run <= 1'b1;
        if (!run) cnt <= '0;
        else if (tick) cnt <= last ? '0 : cnt + 1'b1;
      end
      if (start) begin
        mode_q <= mode; duty_q <= duty; fw_q <= fw_len; per_q <= period;
      end
    end
  end

  logic act, act_fw, act_dbl;
  assign act     = c_w < d_w;
  assign act_fw  = c_w < dfw_w;
  assign act_dbl = c_w < d2_w;

  logic [1:0] leg_a, leg_b;
  always_comb begin
    leg_a = FLT;
    leg_b = FLT;
    if (run) begin
      case (mode_q)
        3'd1: leg_b = act_dbl ? LO : FLT;
        3'd2: begin leg_a = act ? HI : FLT; leg_b = act_fw ? LO : FLT; end
        3'd3: leg_a = act_dbl ? HI : FLT;
        3'd4: leg_b = act_dbl ? HI : FLT;
        3'd5: begin leg_a = act ? LO : FLT; leg_b = act_fw ? HI : FLT; end
        3'd6: leg_a = act_dbl ? LO : FLT;
        default: ;
      endcase
    end
  end

  assign a_hi = leg_a == HI;
  assign a_lo = leg_a == LO;
  assign b_hi = leg_b == HI;
  assign b_lo = leg_b == LO;

  AST_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo)); // R8
  AST_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo)); // R8
  AST_OFF_AFTER_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(a_hi || a_lo || b_hi || b_lo)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && tick && !last) |=> cnt == $past(cnt) + 1'b1); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && !tick) |=> $stable(cnt)); // R5
  AST_TAIL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (mode_q == 3'd2 || mode_q == 3'd5) && !act_fw) |-> !(a_hi || a_lo || b_hi || b_lo)); // R3
  AST_BAD_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (mode_q == 3'd0 || mode_q == 3'd7)) |-> !(a_hi || a_lo || b_hi || b_lo)); // R7
endmodule

// File: tb/fsw_pwm_seq_tb.sv
module fsw_pwm_seq_tb;
  localparam int CW = 16;
  logic clk = 0, rst_n = 0, en = 0, tick = 0;
  logic [2:0] mode = 0;
  logic [CW-1:0] duty = 0, period = 8, fw_len = 0;
  logic a_hi, a_lo, b_hi, b_lo;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  fsw_pwm_seq #(.CW(CW)) u_dut (.clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .mode(mode),
    .duty(duty), .period(period), .fw_len(fw_len), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo));

  always #5 clk = ~clk;

  // reference model state
  bit m_run = 0;
  int m_cnt = 0, m_mode = 0, m_d = 0, m_f = 0, m_p = 0;

  // returns {a_hi,a_lo,b_hi,b_lo}
  function automatic logic [3:0] expect_gates();
    int stage;
    logic [1:0] a, b; // 2'b10 high, 2'b01 low, 2'b00 float
    a = 2'b00; b = 2'b00;
    if (!m_run) return 4'b0000;
    if (m_mode == 2 || m_mode == 5) begin
      if (m_cnt < m_d) stage = 0; else if (m_cnt < m_d + m_f) stage = 1; else stage = 2;
      if (stage == 0) a = (m_mode == 2) ? 2'b10 : 2'b01;
      if (stage <= 1) b = (m_mode == 2) ? 2'b01 : 2'b10;
    end else if (m_mode >= 1 && m_mode <= 6) begin
      int on_len;
      on_len = (2 * m_d > m_p) ? m_p : 2 * m_d;
      if (m_cnt < on_len || (2 * m_d >= m_p && m_d > 0)) begin
        case (m_mode)
          1: b = 2'b01;
          3: a = 2'b10;
          4: b = 2'b10;
          default: a = 2'b01;
        endcase
      end
    end
    return {a, b};
  endfunction

  function automatic string req_tag();
    if (!m_run) return "R9";
    if (m_mode == 2 || m_mode == 5) return "R3";
    if (m_mode == 0 || m_mode == 7) return "R7";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {a_hi, a_lo, b_hi, b_lo};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gates=%b expected=%b (mode=%0d cnt=%0d)", tag, act, exp, m_mode, m_cnt);
    end
    if ((a_hi && a_lo) || (b_hi && b_lo)) begin
      n_bad++;
      $display("FAIL R8: gates=%b expected no leg with both gates on", act);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_run = 0; m_cnt = 0;
    end else if (!en) begin
      m_run = 0; m_cnt = 0;
    end else begin
      bit lat;
      lat = 0;
      if (!m_run) begin m_run = 1; m_cnt = 0; lat = 1; end
      else if (tick) begin
        if (m_cnt + 1 >= m_p) begin m_cnt = 0; lat = 1; end else m_cnt++;
      end
      if (lat) begin m_mode = mode; m_d = duty; m_f = fw_len; m_p = period; end
    end
    @(negedge clk);
    check(req_tag(), expect_gates());
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    check("R1", 4'b0000); // idle after reset, en low

    // directed R2: each mode's active pair at cnt 0, duty 3, period 12, tick every cycle
    for (int m = 1; m <= 6; m++) begin
      logic [3:0] pat [1:6];
      pat[1] = 4'b0001; pat[2] = 4'b1001; pat[3] = 4'b1000;
      pat[4] = 4'b0010; pat[5] = 4'b0110; pat[6] = 4'b0100;
      mode = 3'(m); duty = 3; period = 12; fw_len = 2; tick = 1; en = 1;
      step();
      check("R2", pat[m]);
      en = 0; step();
    end

    // directed R6: mode change mid-period is deferred
    mode = 3; duty = 2; period = 10; fw_len = 0; tick = 1; en = 1;
    repeat (3) step();
    mode = 5;
    step();
    check("R6", 4'b1000); // count 3 < 2*2, still mode 3 leg A high
    repeat (6) step();
    step(); // wrap: mode 5 now at count 0
    check("R6", 4'b0110);

    // directed R3: zero freewheel, mode 2
    en = 0; step();
    mode = 2; duty = 3; fw_len = 0; period = 8; en = 1;
    repeat (3) step();
    step();
    check("R3", 4'b0000); // count 3: freewheel skipped, both float

    // directed R4: saturation
    en = 0; step();
    mode = 4; duty = 9; period = 10; en = 1;
    repeat (12) step();
    check("R4", 4'b0010);

    // zero duty gives all off
    en = 0; step();
    mode = 1; duty = 0; en = 1;
    repeat (5) step();
    check("R4", 4'b0000);

    // R5: period 0 behaves as one tick
    en = 0; step();
    mode = 6; duty = 0; period = 0; en = 1;
    repeat (4) step();

    // R9: drop and restore enable, count restarts
    en = 0; step();
    check("R9", 4'b0000);
    mode = 2; duty = 1; period = 6; fw_len = 1; en = 1;
    step();
    check("R9", 4'b1001);

    // random segments
    for (int s = 0; s < 60; s++) begin
      int len;
      mode   = 3'($urandom_range(0, 7));
      period = CW'($urandom_range(1, 40));
      duty   = CW'($urandom_range(0, 30));
      fw_len = CW'($urandom_range(0, 15));
      en = ($urandom_range(0, 9) != 0);
      len = $urandom_range(5, 120);
      for (int k = 0; k < len; k++) begin
        tick = ($urandom_range(0, 3) != 0);
        step();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule